// File: doc/BRIEF.md
# Interrupt Request Stage Controller

This block sequences the entry into interrupt handling for a small microcoded processor. An asynchronous request line is synchronized and its rising edge latches a request flag. The flag is combined with a strobe that marks the completion of a jump-class step. The first low-to-high transition of that combined condition raises an entry flag. The entry flag stays up for the whole entry phase, and only the sequence reset lowers it again. A second state bit follows the processor clock phase during the entry phase. It records that a falling phase interval has been followed by a rising one.

All state is held in flip-flops on one system clock, and every edge is found by comparing a signal with its registered copy. The entry flag works like a self-locking clocked flop. It has no set/reset latch, so no race between a lingering set and an arriving reset is possible. The combined condition toggles with the clock while jump-class operations run. For that reason only its transitions count, and any transition after the first is ignored.

Top module: `irq_stage_ctrl`

## Requirements
- R1: A rising edge of `irq_line` sets `req_flag` three clock edges after it is sampled: two synchronizer flops, then the latch. `req_flag` stays high until `rst`. If the line is still high when reset ends, that is not a new edge and it does not set the flag again.
- R2: `do_irq` rises only at a clock edge where both `req_flag` and `step_done` were high. A request without a completed step, and a step without a request, never raise it.
- R3: Only a low-to-high transition of (`req_flag` AND `step_done`) sets `do_irq`, at the edge that first samples the condition high. This includes the case where `step_done` was already high when `req_flag` rose.
- R4: While `do_irq` is high, further rising transitions of the condition leave it unchanged. It does not toggle.
- R5: Once set, `do_irq` changes only when `rst` is sampled high.
- R6: If `rst` and a qualifying condition edge are sampled at the same clock edge, reset wins and `do_irq` stays low.
- R7: `rst` is synchronous and active high. At the edge that samples it, it clears `req_flag`, `do_irq` and `stage_flag` together.
- R8: While `do_irq` is high, a falling edge of `clk_phase` arms the stage tracker. The next rising edge of `clk_phase` then sets `stage_flag`, which holds until `rst`. A rising edge without a preceding armed fall does not set it.
- R9: `do_irq_n` is always the complement of `do_irq`. The two are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high sequence reset |
| irq_line | input | 1 | Asynchronous interrupt request line |
| step_done | input | 1 | Strobe: a jump-class step has just completed |
| clk_phase | input | 1 | Processor clock phase, sampled on clk |
| req_flag | output | 1 | Latched request |
| stage_flag | output | 1 | Falling-then-rising phase interval seen during entry |
| do_irq | output | 1 | Interrupt entry phase active |
| do_irq_n | output | 1 | Complement of do_irq |

## Verification
The hardest situation to reach is a condition edge that arrives while the entry flag is already high. It needs a latched request, a first qualifying step, and then more step pulses and phase swings without any reset in between. A vector table builds that state step by step, then pulses `step_done` again and again while checking that `do_irq` holds. Directed tests then bring reset and a qualifying edge into the same cycle. They also raise `step_done` before the request latches, and keep the request line high through a reset.

// File: rtl/irq_stage_pkg.sv
package irq_stage_pkg;

  localparam int unsigned SYNC_DEPTH_DEF = 2;

  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic fall_of(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

  typedef struct packed {
    logic armed;
    logic done;
  } stage_state_t;

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [LAST:0] chain;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import irq_stage_pkg::*;
(
  input  logic clk,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic prev;

  // tracks the signal through reset so a held level is never a new edge
  always_ff @(posedge clk) prev <= sig;

  assign rise = rise_of(sig, prev);
  assign fall = fall_of(sig, prev);
endmodule

// File: rtl/irq_lock_flag.sv
module irq_lock_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_edge,
  output logic q,
  output logic q_n
);
  logic take;

  // set edge only counts while the flag is idle; reset has priority
  assign take = set_edge & ~q;

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (take) q <= 1'b1;
  end

  assign q_n = ~q;
endmodule

// File: rtl/irq_stage_track.sv
module irq_stage_track
  import irq_stage_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic phase,
  output logic stage
);
  logic         ph_rise, ph_fall;
  stage_state_t st;

  irq_edge_det u_phase_edge (
    .clk (clk),
    .sig (phase),
    .rise(ph_rise),
    .fall(ph_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      if (active && ph_fall) st.armed <= 1'b1;
      if (st.armed && ph_rise) st.done <= 1'b1;
    end
  end

  assign stage = st.done;
endmodule

// File: rtl/irq_stage_ctrl.sv
module irq_stage_ctrl
  import irq_stage_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_line,
  input  logic step_done,
  input  logic clk_phase,
  output logic req_flag,
  output logic stage_flag,
  output logic do_irq,
  output logic do_irq_n
);
  logic irq_sync;
  logic irq_rise, irq_fall_unused;
  logic cond;
  logic cond_rise, cond_fall_unused;

  irq_sync_chain #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk),
    .d  (irq_line),
    .q  (irq_sync)
  );

  irq_edge_det u_irq_edge (
    .clk (clk),
    .sig (irq_sync),
    .rise(irq_rise),
    .fall(irq_fall_unused)
  );

  always_ff @(posedge clk) begin
    if (rst)           req_flag <= 1'b0;
    else if (irq_rise) req_flag <= 1'b1;
  end

  assign cond = req_flag & step_done;

  irq_edge_det u_cond_edge (
    .clk (clk),
    .sig (cond),
    .rise(cond_rise),
    .fall(cond_fall_unused)
  );

  irq_lock_flag u_entry (
    .clk     (clk),
    .rst     (rst),
    .set_edge(cond_rise),
    .q       (do_irq),
    .q_n     (do_irq_n)
  );

  irq_stage_track u_stage (
    .clk   (clk),
    .rst   (rst),
    .active(do_irq),
    .phase (clk_phase),
    .stage (stage_flag)
  );
endmodule

// File: rtl/irq_stage_ctrl_chk.sv
module irq_stage_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic step_done,
  input logic req_flag,
  input logic stage_flag,
  input logic do_irq,
  input logic do_irq_n
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= 2'd1;
    else if (since_rst != 2'd0 && since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic live;
  assign live = (since_rst >= 2'd2);

  assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (live && req_flag) |=> req_flag);

  assert_entry_needs_both_R2: assert property (@(posedge clk) disable iff (rst)
    (live && !do_irq) |=> (!do_irq || $past(req_flag && step_done)));

  assert_entry_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (live && do_irq) |=> do_irq);

  assert_reset_clears_R7: assert property (@(posedge clk)
    (live && rst) |=> (!req_flag && !do_irq && !stage_flag));

  assert_stage_in_entry_R8: assert property (@(posedge clk) disable iff (rst)
    (live && stage_flag) |-> do_irq);

  always_comb begin
    if (live) assert_complement_R9: assert (do_irq != do_irq_n);
  end
endmodule

bind irq_stage_ctrl irq_stage_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .step_done (step_done),
  .req_flag  (req_flag),
  .stage_flag(stage_flag),
  .do_irq    (do_irq),
  .do_irq_n  (do_irq_n)
);

// File: tb/irq_stage_ctrl_test.sv
module irq_stage_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_line = 1'b0;
  logic step_done = 1'b0;
  logic clk_phase = 1'b1;
  logic req_flag, stage_flag, do_irq, do_irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_stage_ctrl uut (
    .clk(clk), .rst(rst), .irq_line(irq_line), .step_done(step_done),
    .clk_phase(clk_phase), .req_flag(req_flag), .stage_flag(stage_flag),
    .do_irq(do_irq), .do_irq_n(do_irq_n)
  );

  // {irq, step, phase, rst, exp_req, exp_do, exp_stage}
  localparam int NV = 15;
  localparam logic [6:0] VEC [NV] = '{
    7'b0011_000, // reset R7
    7'b0010_000,
    7'b1010_000, // first sync flop R1
    7'b1010_000, // second sync flop R1
    7'b1010_100, // request latched, no step R10 -> R2
    7'b1010_100,
    7'b1110_110, // condition rises R3
    7'b1010_110,
    7'b1110_110, // second edge ignored R4
    7'b1000_110, // phase falls, arms R8
    7'b1110_111, // phase rises, stage set R8
    7'b1000_111,
    7'b1011_000, // reset clears all R7
    7'b1010_000, // line held high, no relatch R1
    7'b1110_000  // step without request R2
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic i, input logic s, input logic p, input logic r);
    irq_line = i; step_done = s; clk_phase = p; rst = r;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag, input logic er, input logic ed, input logic es);
    check({tag, " req_flag"}, req_flag, er);
    check({tag, " do_irq"}, do_irq, ed);
    check({tag, " stage_flag"}, stage_flag, es);
    check("R9 complement", do_irq_n, ~ed);
  endtask

  initial begin
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][6], VEC[k][5], VEC[k][4], VEC[k][3]);
      check_all($sformatf("vec%0d", k), VEC[k][2], VEC[k][1], VEC[k][0]);
    end

    // R5 / R4: long run of step pulses and phase swings while entry is active
    drive(0, 0, 1, 1);
    for (int k = 0; k < 4; k++) drive(0, 0, 1, 0);
    for (int k = 0; k < 3; k++) drive(1, 0, 1, 0);
    check_all("R1 relatch after low", 1'b1, 1'b0, 1'b0);
    drive(1, 1, 1, 0);
    check_all("R3 entry", 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 20; k++) begin
      drive(1, k[0], k[1], 0);
      check("R5 entry holds", do_irq, 1'b1);
    end

    // R6: reset and qualifying edge in the same cycle
    drive(0, 0, 1, 1);
    for (int k = 0; k < 3; k++) drive(0, 0, 1, 0);
    for (int k = 0; k < 3; k++) drive(1, 0, 1, 0);
    check("R6 setup req", req_flag, 1'b1);
    drive(1, 1, 1, 1);
    check_all("R6 reset wins", 1'b0, 1'b0, 1'b0);
    drive(1, 1, 1, 0);
    check("R6 no late set", do_irq, 1'b0);

    // R3: step already high when the request latches
    drive(0, 1, 1, 1);
    for (int k = 0; k < 3; k++) drive(0, 1, 1, 0);
    drive(1, 1, 1, 0);
    drive(1, 1, 1, 0);
    drive(1, 1, 1, 0);
    check_all("R3 req latches first", 1'b1, 1'b0, 1'b0);
    drive(1, 1, 1, 0);
    check_all("R3 condition edge from req", 1'b1, 1'b1, 1'b0);

    // R8: a rise with no armed fall does not set stage
    drive(1, 0, 0, 1);
    drive(1, 0, 1, 0);
    check("R8 no stage without entry", stage_flag, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule